// File: doc/BRIEF.md
# Operand Effective Address Calculator

This block works out where a memory operand lives for a two-operand-register-file processor with eight address registers and eight data registers. The decode stage gives it the three-bit mode field and three-bit register field of the instruction, plus the operand size. The register file supplies the current address and data register values. The fetch stage supplies up to two extension words. From these the block forms the operand address. It also reports whether the selected address register must be written back, and with which value, for the two auto-modify modes. It reports how many extension words the mode consumed, so that the fetch stage can advance past them.

A request is presented with `in_valid` high for one clock cycle. All results are registered. They appear with `out_valid` one clock edge later, and they hold their value until the next request. Modes that name no memory operand produce a zero address, no write-back and no extension words. These modes are register direct, address register direct and the unused register codes of mode 7.

Top module: `ea_calc`

## Requirements
- R1: While `rst` is high, and on the first clock edge that `rst` is released, `out_valid`, `an_we`, `ext_used` and `ea_addr` are all zero.
- R2: `out_valid` is high exactly in the cycle after a clock edge that sampled `in_valid` high. When `in_valid` is low, every result output keeps its previous value.
- R3: Mode 2 (register indirect): `ea_addr` equals the selected address register, `an_we` is 0 and `ext_used` is 0.
- R4: Mode 3 (post-increment): `ea_addr` is the unmodified register. `an_we` is 1 and `an_wdata` is the register plus the step. The step is 1 for `op_size` 0 (byte), 2 for `op_size` 1 (word) and 4 for `op_size` 2 or 3 (long). `ext_used` is 0.
- R5: Mode 4 (pre-decrement): `an_wdata` is the register minus the step, and `ea_addr` equals that reduced value. `an_we` is 1 and `ext_used` is 0.
- R6: A byte-size access in mode 3 or mode 4 through register 7 steps by 2 instead of 1.
- R7: Mode 5 (displacement): `ea_addr` is the register plus `ext_w0`, with `ext_w0` sign-extended from bit 15. `ext_used` is 1.
- R8: Mode 6 (indexed): `ea_addr` is the sum of three terms: the base register, `ext_w0[7:0]` sign-extended, and an index value. Bit 15 of `ext_w0` selects the index file: 1 for address registers, 0 for data registers. Bits 14:12 give the index register number. Bit 11 selects the index length: 1 uses the full register, 0 uses its low 16 bits sign-extended. `ext_used` is 1.
- R9: Mode 7, register 0 (absolute short): `ea_addr` is `ext_w0` sign-extended from bit 15, and `ext_used` is 1.
- R10: Mode 7, register 1 (absolute long): `ea_addr` is `{ext_w0, ext_w1}`, and `ext_used` is 2.
- R11: Modes 0 and 1, and mode 7 with register codes 2 to 7, give `ea_addr` = 0, `an_we` = 0 and `ext_used` = 0.
- R12: `an_we` is high only for a result of mode 3 or mode 4, and `an_idx` then equals that request's register field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, one cycle per request |
| ea_mode | input | 3 | Mode field of the instruction |
| ea_reg | input | 3 | Register field of the instruction |
| op_size | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 long |
| areg_flat | input | NREG*AW | Address registers, register i at bits [i*AW +: AW] |
| dreg_flat | input | NREG*AW | Data registers, same packing |
| ext_w0 | input | EW | First extension word |
| ext_w1 | input | EW | Second extension word (low half of an absolute long) |
| out_valid | output | 1 | Results below are new this cycle |
| ea_addr | output | AW | Effective address |
| an_we | output | 1 | Address register write-back enable |
| an_idx | output | 3 | Address register to write |
| an_wdata | output | AW | Value to write |
| ext_used | output | 2 | Extension words consumed (0, 1 or 2) |

## Verification
The block has one register stage, so any wrong internal value appears on the ports at the very next edge after the request. A wrong step size or a swapped update order in the auto-modify modes shows up in that cycle as a mismatch between `ea_addr` and `an_wdata`. A result register that fails to hold its value becomes visible in an idle cycle that follows a request. A bad sign extension only shows when the bench uses a negative displacement, a negative absolute-short word or a negative word index, so each of these cases is driven.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int ADDR_W = 32;
  localparam int EXT_W  = 16;
  localparam int NUM_REG = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LONG_ALT = 2'd3
  } size_e;

  localparam logic [2:0] MODE_IND  = 3'd2;
  localparam logic [2:0] MODE_POST = 3'd3;
  localparam logic [2:0] MODE_PRE  = 3'd4;
  localparam logic [2:0] MODE_DISP = 3'd5;
  localparam logic [2:0] MODE_IDX  = 3'd6;
  localparam logic [2:0] MODE_EXT  = 3'd7;
  localparam logic [2:0] XREG_ABS_S = 3'd0;
  localparam logic [2:0] XREG_ABS_L = 3'd1;
endpackage

// File: rtl/ea_step.sv
module ea_step
  import ea_pkg::*;
#(
  parameter int SP_REG = 7
) (
  input  logic [1:0] op_size,
  input  logic [2:0] reg_sel,
  output logic [2:0] step
);
  size_e sz;
  always_comb begin
    sz = size_e'(op_size);
    unique case (sz)
      SZ_BYTE: step = (reg_sel == 3'(SP_REG)) ? 3'd2 : 3'd1;
      SZ_WORD: step = 3'd2;
      default: step = 3'd4;
    endcase
  end
endmodule

// File: rtl/ea_index.sv
module ea_index #(
  parameter int AW   = 32,
  parameter int NREG = 8,
  localparam int RSEL = $clog2(NREG)
) (
  input  logic [NREG*AW-1:0] areg_flat,
  input  logic [NREG*AW-1:0] dreg_flat,
  input  logic               use_areg,
  input  logic [RSEL-1:0]    idx_reg,
  input  logic               idx_long,
  input  logic [7:0]         disp8,
  output logic [AW-1:0]      offset
);
  logic [AW-1:0] raw;
  logic [AW-1:0] idx_val;
  logic [AW-1:0] disp_ext;

  always_comb begin
    raw      = use_areg ? areg_flat[idx_reg*AW +: AW] : dreg_flat[idx_reg*AW +: AW];
    idx_val  = idx_long ? raw : {{(AW-16){raw[15]}}, raw[15:0]};
    disp_ext = {{(AW-8){disp8[7]}}, disp8};
    offset   = idx_val + disp_ext;
  end
endmodule

// File: rtl/ea_core.sv
module ea_core
  import ea_pkg::*;
#(
  parameter int AW   = 32,
  parameter int EW   = 16,
  parameter int NREG = 8
) (
  input  logic [2:0]         ea_mode,
  input  logic [2:0]         ea_reg,
  input  logic [1:0]         op_size,
  input  logic [NREG*AW-1:0] areg_flat,
  input  logic [NREG*AW-1:0] dreg_flat,
  input  logic [EW-1:0]      ext_w0,
  input  logic [EW-1:0]      ext_w1,
  output logic [AW-1:0]      nx_addr,
  output logic               nx_we,
  output logic [AW-1:0]      nx_wdata,
  output logic [1:0]         nx_ext
);
  logic [2:0]    step;
  logic [AW-1:0] idx_off;
  logic [AW-1:0] base;
  logic [AW-1:0] step_w;
  logic [AW-1:0] w0_sx;

  ea_step #(.SP_REG(NREG-1)) u_step (
    .op_size (op_size),
    .reg_sel (ea_reg),
    .step    (step)
  );

  ea_index #(.AW(AW), .NREG(NREG)) u_index (
    .areg_flat (areg_flat),
    .dreg_flat (dreg_flat),
    .use_areg  (ext_w0[15]),
    .idx_reg   (ext_w0[14:12]),
    .idx_long  (ext_w0[11]),
    .disp8     (ext_w0[7:0]),
    .offset    (idx_off)
  );

  always_comb begin
    base     = areg_flat[ea_reg*AW +: AW];
    step_w   = AW'(step);
    w0_sx    = {{(AW-EW){ext_w0[EW-1]}}, ext_w0};
    nx_addr  = '0;
    nx_we    = 1'b0;
    nx_wdata = '0;
    nx_ext   = 2'd0;
    case (ea_mode)
      MODE_IND:  nx_addr = base;
      MODE_POST: begin
        nx_addr  = base;
        nx_we    = 1'b1;
        nx_wdata = base + step_w;
      end
      MODE_PRE: begin
        nx_wdata = base - step_w;
        nx_addr  = base - step_w;
        nx_we    = 1'b1;
      end
      MODE_DISP: begin
        nx_addr = base + w0_sx;
        nx_ext  = 2'd1;
      end
      MODE_IDX: begin
        nx_addr = base + idx_off;
        nx_ext  = 2'd1;
      end
      MODE_EXT: begin
        if (ea_reg == XREG_ABS_S) begin
          nx_addr = w0_sx;
          nx_ext  = 2'd1;
        end else if (ea_reg == XREG_ABS_L) begin
          nx_addr = AW'({ext_w0, ext_w1});
          nx_ext  = 2'd2;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int EW   = EXT_W,
  parameter int NREG = NUM_REG
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [2:0]         ea_mode,
  input  logic [2:0]         ea_reg,
  input  logic [1:0]         op_size,
  input  logic [NREG*AW-1:0] areg_flat,
  input  logic [NREG*AW-1:0] dreg_flat,
  input  logic [EW-1:0]      ext_w0,
  input  logic [EW-1:0]      ext_w1,
  output logic               out_valid,
  output logic [AW-1:0]      ea_addr,
  output logic               an_we,
  output logic [2:0]         an_idx,
  output logic [AW-1:0]      an_wdata,
  output logic [1:0]         ext_used
);
  logic [AW-1:0] nx_addr;
  logic          nx_we;
  logic [AW-1:0] nx_wdata;
  logic [1:0]    nx_ext;

  ea_core #(.AW(AW), .EW(EW), .NREG(NREG)) u_core (
    .ea_mode   (ea_mode),
    .ea_reg    (ea_reg),
    .op_size   (op_size),
    .areg_flat (areg_flat),
    .dreg_flat (dreg_flat),
    .ext_w0    (ext_w0),
    .ext_w1    (ext_w1),
    .nx_addr   (nx_addr),
    .nx_we     (nx_we),
    .nx_wdata  (nx_wdata),
    .nx_ext    (nx_ext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      ea_addr   <= '0;
      an_we     <= 1'b0;
      an_idx    <= '0;
      an_wdata  <= '0;
      ext_used  <= 2'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ea_addr  <= nx_addr;
        an_we    <= nx_we;
        an_idx   <= ea_reg;
        an_wdata <= nx_wdata;
        ext_used <= nx_ext;
      end
    end
  end
endmodule

// File: rtl/ea_calc_chk.sv
module ea_calc_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    ea_mode,
  input logic [2:0]    ea_reg,
  input logic          out_valid,
  input logic [AW-1:0] ea_addr,
  input logic          an_we,
  input logic [2:0]    an_idx,
  input logic [AW-1:0] an_wdata,
  input logic [1:0]    ext_used
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R2
  hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(ea_addr) && $stable(ext_used));
  // R12
  we_mode_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && ea_mode != 3'd3 && ea_mode != 3'd4 |=> !an_we);
  // R12
  we_idx_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> an_idx == $past(ea_reg));
  // R4
  post_step_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && ea_mode == 3'd3 |=> an_we &&
      ((an_wdata - ea_addr) == AW'(1) || (an_wdata - ea_addr) == AW'(2) ||
       (an_wdata - ea_addr) == AW'(4)));
  // R5
  pre_order_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && ea_mode == 3'd4 |=> an_we && ea_addr == an_wdata);
  // R10
  ext_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ext_used != 2'd3);
endmodule

bind ea_calc ea_calc_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .ea_mode   (ea_mode),
  .ea_reg    (ea_reg),
  .out_valid (out_valid),
  .ea_addr   (ea_addr),
  .an_we     (an_we),
  .an_idx    (an_idx),
  .an_wdata  (an_wdata),
  .ext_used  (ext_used)
);

// File: tb/sim_ea_calc.sv
`timescale 1ns/1ps
module sim_ea_calc;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [2:0]   ea_mode = '0;
  logic [2:0]   ea_reg = '0;
  logic [1:0]   op_size = '0;
  logic [255:0] areg_flat;
  logic [255:0] dreg_flat;
  logic [15:0]  ext_w0 = '0;
  logic [15:0]  ext_w1 = '0;
  logic         out_valid;
  logic [31:0]  ea_addr;
  logic         an_we;
  logic [2:0]   an_idx;
  logic [31:0]  an_wdata;
  logic [1:0]   ext_used;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ea_calc u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ea_mode(ea_mode), .ea_reg(ea_reg),
    .op_size(op_size), .areg_flat(areg_flat), .dreg_flat(dreg_flat),
    .ext_w0(ext_w0), .ext_w1(ext_w1), .out_valid(out_valid), .ea_addr(ea_addr),
    .an_we(an_we), .an_idx(an_idx), .an_wdata(an_wdata), .ext_used(ext_used)
  );

  function automatic logic [31:0] ar(input int i);
    return areg_flat[i*32 +: 32];
  endfunction
  function automatic logic [31:0] dr(input int i);
    return dreg_flat[i*32 +: 32];
  endfunction
  function automatic logic [31:0] sx16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Issue one request, then compare every result field with expectation.
  task automatic do_op(input string req, input logic [2:0] m, input logic [2:0] r,
                       input logic [1:0] sz, input logic [15:0] e0, input logic [15:0] e1,
                       input logic [31:0] x_addr, input logic x_we,
                       input logic [31:0] x_wdata, input logic [1:0] x_ext);
    ea_mode = m; ea_reg = r; op_size = sz; ext_w0 = e0; ext_w1 = e1; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " addr"}, ea_addr, x_addr);
    check({req, " we"}, {31'd0, an_we}, {31'd0, x_we});
    check({req, " ext"}, {30'd0, ext_used}, {30'd0, x_ext});
    if (x_we) begin
      check({req, " wdata"}, an_wdata, x_wdata);
      check({req, " idx"}, {29'd0, an_idx}, {29'd0, r});
    end
  endtask

  task automatic t_reset();
    // R1
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 addr", ea_addr, 32'd0);
    check("R1 we", {31'd0, an_we}, 32'd0);
    check("R1 ext", {30'd0, ext_used}, 32'd0);
  endtask

  task automatic t_indirect();
    do_op("R3 a2", 3'd2, 3'd2, 2'd1, 16'h0, 16'h0, ar(2), 1'b0, 32'd0, 2'd0);
    do_op("R3 a5", 3'd2, 3'd5, 2'd2, 16'hFFFF, 16'h0, ar(5), 1'b0, 32'd0, 2'd0);
  endtask

  task automatic t_postinc();
    do_op("R4 byte", 3'd3, 3'd1, 2'd0, 16'h0, 16'h0, ar(1), 1'b1, ar(1) + 32'd1, 2'd0);
    do_op("R4 word", 3'd3, 3'd1, 2'd1, 16'h0, 16'h0, ar(1), 1'b1, ar(1) + 32'd2, 2'd0);
    do_op("R4 long", 3'd3, 3'd1, 2'd2, 16'h0, 16'h0, ar(1), 1'b1, ar(1) + 32'd4, 2'd0);
    do_op("R4 long3", 3'd3, 3'd6, 2'd3, 16'h0, 16'h0, ar(6), 1'b1, ar(6) + 32'd4, 2'd0);
    do_op("R6 post sp", 3'd3, 3'd7, 2'd0, 16'h0, 16'h0, ar(7), 1'b1, ar(7) + 32'd2, 2'd0);
  endtask

  task automatic t_predec();
    do_op("R5 byte", 3'd4, 3'd0, 2'd0, 16'h0, 16'h0, ar(0) - 32'd1, 1'b1, ar(0) - 32'd1, 2'd0);
    do_op("R5 word", 3'd4, 3'd0, 2'd1, 16'h0, 16'h0, ar(0) - 32'd2, 1'b1, ar(0) - 32'd2, 2'd0);
    do_op("R5 long", 3'd4, 3'd0, 2'd2, 16'h0, 16'h0, ar(0) - 32'd4, 1'b1, ar(0) - 32'd4, 2'd0);
    do_op("R6 pre sp", 3'd4, 3'd7, 2'd0, 16'h0, 16'h0, ar(7) - 32'd2, 1'b1, ar(7) - 32'd2, 2'd0);
  endtask

  task automatic t_disp();
    do_op("R7 pos", 3'd5, 3'd3, 2'd1, 16'h0040, 16'h0, ar(3) + 32'h40, 1'b0, 32'd0, 2'd1);
    do_op("R7 neg", 3'd5, 3'd3, 2'd1, 16'hFFF0, 16'h0, ar(3) - 32'h10, 1'b0, 32'd0, 2'd1);
  endtask

  task automatic t_index();
    // R8: ext = {A/D, reg[2:0], long, 3'b000, disp8}
    do_op("R8 areg long", 3'd6, 3'd2, 2'd1, {1'b1, 3'd4, 1'b1, 3'd0, 8'h10}, 16'h0,
          ar(2) + ar(4) + 32'h10, 1'b0, 32'd0, 2'd1);
    do_op("R8 dreg word", 3'd6, 3'd2, 2'd1, {1'b0, 3'd5, 1'b0, 3'd0, 8'h80}, 16'h0,
          ar(2) + sx16(dr(5)[15:0]) - 32'd128, 1'b0, 32'd0, 2'd1);
    do_op("R8 dreg long", 3'd6, 3'd1, 2'd2, {1'b0, 3'd5, 1'b1, 3'd0, 8'h7F}, 16'h0,
          ar(1) + dr(5) + 32'h7F, 1'b0, 32'd0, 2'd1);
    do_op("R8 dreg neg", 3'd6, 3'd0, 2'd2, {1'b0, 3'd3, 1'b0, 3'd0, 8'hFF}, 16'h0,
          ar(0) - 32'd16 - 32'd1, 1'b0, 32'd0, 2'd1);
  endtask

  task automatic t_abs();
    do_op("R9 pos", 3'd7, 3'd0, 2'd1, 16'h1234, 16'h0, 32'h0000_1234, 1'b0, 32'd0, 2'd1);
    do_op("R9 neg", 3'd7, 3'd0, 2'd1, 16'h8000, 16'h0, 32'hFFFF_8000, 1'b0, 32'd0, 2'd1);
    do_op("R10 long", 3'd7, 3'd1, 2'd2, 16'h89AB, 16'hCDEF, 32'h89AB_CDEF, 1'b0, 32'd0, 2'd2);
  endtask

  task automatic t_nonmem();
    do_op("R11 m0", 3'd0, 3'd3, 2'd1, 16'h1111, 16'h2222, 32'd0, 1'b0, 32'd0, 2'd0);
    do_op("R11 m1", 3'd1, 3'd4, 2'd2, 16'h1111, 16'h2222, 32'd0, 1'b0, 32'd0, 2'd0);
    do_op("R11 m7r2", 3'd7, 3'd2, 2'd1, 16'h1111, 16'h2222, 32'd0, 1'b0, 32'd0, 2'd0);
    do_op("R11 m7r4", 3'd7, 3'd4, 2'd1, 16'h1111, 16'h2222, 32'd0, 1'b0, 32'd0, 2'd0);
  endtask

  task automatic t_hold();
    do_op("R2 setup", 3'd3, 3'd2, 2'd1, 16'h0, 16'h0, ar(2), 1'b1, ar(2) + 32'd2, 2'd0);
    ea_mode = 3'd7; ea_reg = 3'd1; ext_w0 = 16'hDEAD; ext_w1 = 16'hBEEF;
    @(posedge clk);
    @(negedge clk);
    // R2: idle cycle, results unchanged
    check("R2 idle valid", {31'd0, out_valid}, 32'd0);
    check("R2 hold addr", ea_addr, ar(2));
    check("R2 hold we", {31'd0, an_we}, 32'd1);
    check("R2 hold wdata", an_wdata, ar(2) + 32'd2);
    check("R2 hold ext", {30'd0, ext_used}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      areg_flat[i*32 +: 32] = 32'h0001_0000 + 32'(i) * 32'h100;
      dreg_flat[i*32 +: 32] = 32'h10 * 32'(i);
    end
    areg_flat[7*32 +: 32] = 32'h0000_8000;
    dreg_flat[3*32 +: 32] = 32'hFFFF_FFF0;
    dreg_flat[5*32 +: 32] = 32'h0001_8000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    t_reset();
    t_indirect();
    t_postinc();
    t_predec();
    t_disp();
    t_index();
    t_abs();
    t_nonmem();
    t_hold();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule